// File: doc/BRIEF.md
# SPI Master with Clock-Stop Framing

This block is a synchronous serial master that exchanges one word with a single slave for each start request. It shifts the transmit word out and receives the reply word in the same transfer. The word length can be set from 4 to 32 bits, and the most significant bit goes first. The serial clock comes from the system clock through a programmable divider. The clock idles low and runs only while a word is in flight. An active-low select frames the word, and a data-output enable lets the pad release the line.

Select leads the first clock rise by one low-phase length. The low phase depends on the parity of the divider. Transmit bits change on rising clock edges and the slave's reply is sampled on falling edges. After the last falling edge the output enable drops one low phase later. Select is released one full clock period after that last falling edge. A one-cycle done pulse marks the release, and the received word is valid from that cycle on.

Top module: `spim_clkstop`

## Requirements
- R1: With D = max(div, 1), consecutive rising edges of `sclk` within a transfer are D+1 system cycles apart. A divider of 0 behaves exactly like 1.
- R2: `sclk` stays high for D+1-L cycles of each period. The low length is L = (D+1)/2 when D is odd and L = D/2 when D is even.
- R3: `ss_n` falls in the cycle after a start is accepted. The first rising edge of `sclk` comes exactly L cycles after `ss_n` falls, and `sclk` is never high while `ss_n` is high.
- R4: `sdo` carries the n-bit word `tx_word[n-1:0]` most significant bit first. Bit n-1 is present from the fall of `ss_n`, and each later bit appears on a rising `sclk` edge. `sdo` is stable while `sclk` is high.
- R5: `sdi` is sampled on each falling `sclk` edge, first bit as the MSB. `rx_word` holds the n received bits in bits [n-1:0], and its higher bits are zero.
- R6: `sdo_oe` is high from the fall of `ss_n` until exactly L cycles after the last falling `sclk` edge, then low. It is low whenever `ss_n` is high.
- R7: `ss_n` returns high exactly D+1 cycles after the last falling `sclk` edge.
- R8: `done` is high for exactly one cycle per transfer, in the first cycle `ss_n` is high again. `rx_word` is valid in that cycle and holds its value until the next done.
- R9: In reset and between transfers, `ss_n`=1, `sclk`=0, `sdo_oe`=0 and `done`=0.
- R10: The word length n is `word_len` clamped to the range 4 to 32. Values below 4 give 4 bits and values above 32 give 32 bits.
- R11: A `start` that arrives while a transfer is active is ignored. The word in flight is unchanged, only one done results, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to begin a transfer (taken only while idle) |
| tx_word | input | 32 | Word to transmit, right-aligned |
| div | input | 8 | Clock divider value D (0 treated as 1) |
| word_len | input | 6 | Bits per word, clamped to 4..32 |
| sdi | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| sdo | output | 1 | Serial data to the slave |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| rx_word | output | 32 | Received word, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The hardest timing to pin down is the relation between the parity-dependent low phase and the frame edges. The select lead, the enable release and the select lag all move by one cycle between odd and even dividers. The sweep therefore covers every divider from 0 to 9 and the largest divider, across several word lengths. For each transfer the bench measures every edge distance in system cycles against formulas derived from D. A reply model drives `sdi` on rising clock edges, so a sample taken on the wrong edge corrupts the received word. A second start raised mid-frame with a different word covers the ignored-request case. The bench then watches after done to confirm that no second frame begins.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_TAIL = 3'd4
  } spim_state_e;
endpackage

// File: rtl/spim_phase.sv
module spim_phase #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] low_len_o,
  output logic [DIV_W-1:0] high_len_o
);
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W:0]   period;
  logic [DIV_W-1:0] low_len;

  always_comb begin
    d_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
    period = (DIV_W+1)'(d_eff) + (DIV_W+1)'(1);
    if (d_eff[0]) low_len = period[DIV_W:1];
    else          low_len = {1'b0, d_eff[DIV_W-1:1]};
  end

  assign low_len_o  = low_len;
  assign high_len_o = DIV_W'(period - (DIV_W+1)'(low_len));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] low_len_i,
  input  logic [DIV_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             finish_o,
  output logic             sclk_o,
  output logic             ss_n_o,
  output logic             oe_o
);
  spim_state_e      state_q, state_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] bitc_q, bitc_n;
  logic [DIV_W-1:0] lo_q, hi_q;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] lim;
  logic             phase_end, last_bit;

  always_comb begin
    lim       = (state_q == ST_HIGH || state_q == ST_TAIL) ? hi_q : lo_q;
    phase_end = (cnt_q == lim - DIV_W'(1));
    last_bit  = (bitc_q == len_q - LEN_W'(1));
    state_n   = state_q;
    cnt_n     = phase_end ? '0 : cnt_q + DIV_W'(1);
    bitc_n    = bitc_q;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    sample_o  = 1'b0;
    finish_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_n  = '0;
        bitc_n = '0;
        if (start_i) begin
          state_n = ST_LEAD;
          load_o  = 1'b1;
        end
      end
      ST_LEAD: if (phase_end) state_n = ST_HIGH;
      ST_HIGH: if (phase_end) begin
        state_n  = ST_LOW;
        sample_o = 1'b1;
      end
      ST_LOW: if (phase_end) begin
        if (last_bit) state_n = ST_TAIL;
        else begin
          state_n = ST_HIGH;
          shift_o = 1'b1;
          bitc_n  = bitc_q + LEN_W'(1);
        end
      end
      ST_TAIL: if (phase_end) begin
        state_n  = ST_IDLE;
        finish_o = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitc_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bitc_q  <= bitc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      len_q <= '0;
    end else if (load_o) begin
      lo_q  <= low_len_i;
      hi_q  <= high_len_i;
      len_q <= len_i;
    end
  end

  assign sclk_o = (state_q == ST_HIGH);
  assign ss_n_o = (state_q == ST_IDLE);
  assign oe_o   = (state_q == ST_LEAD) || (state_q == ST_HIGH) || (state_q == ST_LOW);

  // R2: the phase counter never passes the length of the current phase
  p_cnt_in_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (cnt_q < lim));

  // R10: the bit counter stays inside the latched word length
  p_bits_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (bitc_q < len_q));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic                sample_i,
  input  logic                finish_i,
  input  logic [MAX_BITS-1:0] tx_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                sdi_i,
  output logic                sdo_o,
  output logic [MAX_BITS-1:0] rx_o
);
  logic [MAX_BITS-1:0] tx_q, tx_n;
  logic [MAX_BITS-1:0] rs_q, rs_n;
  logic [MAX_BITS-1:0] rx_q;

  always_comb begin
    tx_n = tx_q;
    rs_n = rs_q;
    if (load_i) begin
      tx_n = tx_i << (LEN_W'(MAX_BITS) - len_i);
      rs_n = '0;
    end else begin
      if (shift_i)  tx_n = {tx_q[MAX_BITS-2:0], 1'b0};
      if (sample_i) rs_n = {rs_q[MAX_BITS-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rs_q <= '0;
    end else begin
      tx_q <= tx_n;
      rs_q <= rs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= '0;
    else if (finish_i) rx_q <= rs_q;
  end

  assign sdo_o = tx_q[MAX_BITS-1];
  assign rx_o  = rx_q;

  // R5: a word is never captured in the same cycle a new one is loaded
  p_no_load_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && finish_i));
endmodule

// File: rtl/spim_clkstop.sv
module spim_clkstop #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [DIV_W-1:0]    div,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                sdi,
  output logic                sclk,
  output logic                ss_n,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                done
);
  logic [DIV_W-1:0] low_len, high_len;
  logic [LEN_W-1:0] len_c;
  logic             load, shift, sample, finish;
  logic             done_q;

  always_comb begin
    if (word_len < LEN_W'(MIN_BITS))      len_c = LEN_W'(MIN_BITS);
    else if (word_len > LEN_W'(MAX_BITS)) len_c = LEN_W'(MAX_BITS);
    else                                  len_c = word_len;
  end

  spim_phase #(.DIV_W(DIV_W)) u_phase (
    .div_i      (div),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  spim_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .len_i      (len_c),
    .load_o     (load),
    .shift_o    (shift),
    .sample_o   (sample),
    .finish_o   (finish),
    .sclk_o     (sclk),
    .ss_n_o     (ss_n),
    .oe_o       (sdo_oe)
  );

  spim_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .shift_i  (shift),
    .sample_i (sample),
    .finish_i (finish),
    .tx_i     (tx_word),
    .len_i    (len_c),
    .sdi_i    (sdi),
    .sdo_o    (sdo),
    .rx_o     (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end
  assign done = done_q;

  // R3: the serial clock is only ever high inside a selected frame
  p_clk_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);

  // R4: transmit data holds still while the clock is high
  p_sdo_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R6: the data output is released whenever select is inactive
  p_oe_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sdo_oe);

  // R8: done lasts one cycle and coincides with select release
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);
endmodule

// File: tb/spim_clkstop_bench.sv
module spim_clkstop_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, sdi;
  logic [31:0] tx_word;
  logic [7:0]  div;
  logic [5:0]  word_len;
  logic        sclk, ss_n, sdo, sdo_oe, done;
  logic [31:0] rx_word;

  int errors = 0;
  int checks = 0;

  spim_clkstop u_spim_clkstop (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .div(div),
    .word_len(word_len), .sdi(sdi), .sclk(sclk), .ss_n(ss_n), .sdo(sdo),
    .sdo_oe(sdo_oe), .rx_word(rx_word), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input int dv, input int ln, input logic [31:0] tx,
                          input logic [31:0] sl, input bit poke);
    int d, p, l, h, n, k, nrise, last_rise, last_fall;
    int t_ssfall, t_ssrise, t_oefall, t_done, lead, done_cnt;
    int per_err, hi_err, mosi_err, restart;
    bit prev_ss, prev_sclk, prev_oe;
    logic [31:0] mask;
    d = (dv == 0) ? 1 : dv;
    p = d + 1;
    l = (d % 2 == 1) ? p / 2 : d / 2;
    h = p - l;
    n = (ln < 4) ? 4 : (ln > 32) ? 32 : ln;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    nrise = 0; last_rise = 0; last_fall = 0; t_ssfall = -1; t_ssrise = -1;
    t_oefall = -1; t_done = -1; lead = -1; done_cnt = 0;
    per_err = 0; hi_err = 0; mosi_err = 0; restart = 0;
    prev_ss = 1'b1; prev_sclk = 1'b0; prev_oe = 1'b0;
    @(negedge clk);
    div = 8'(dv); word_len = 6'(ln); tx_word = tx; start = 1'b1;
    k = 0;
    while (t_ssrise < 0 || k < t_ssrise + 6) begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (poke && t_ssfall >= 0 && k == t_ssfall + 3) begin
        start = 1'b1;
        tx_word = ~tx;
      end
      if (prev_ss && !ss_n) begin
        if (t_ssfall >= 0) restart++;
        else begin
          t_ssfall = k;
          sdi = sl[n-1];
        end
      end
      if (!prev_sclk && sclk) begin
        if (nrise == 0) lead = k - t_ssfall;
        else if (k - last_rise != p) per_err++;
        if (nrise < n && sdo !== tx[n-1-nrise]) mosi_err++;
        if (!sdo_oe) mosi_err++;
        if (nrise >= 1 && nrise < n) sdi = sl[n-1-nrise];
        last_rise = k;
        nrise++;
      end
      if (prev_sclk && !sclk) begin
        if (k - last_rise != h) hi_err++;
        last_fall = k;
      end
      if (prev_oe && !sdo_oe) t_oefall = k;
      if (done) begin
        done_cnt++;
        t_done = k;
        chk(rx_word === (sl & mask), "R5", "received word", rx_word, sl & mask);
      end
      if (!prev_ss && ss_n) t_ssrise = k;
      prev_ss = ss_n; prev_sclk = sclk; prev_oe = sdo_oe;
    end
    chk(lead == l, "R3", "select lead", lead, l);
    chk(per_err == 0, "R1", "period errors", per_err, 0);
    chk(hi_err == 0, "R2", "high-phase errors", hi_err, 0);
    chk(mosi_err == 0, "R4", "sdo bit errors", mosi_err, 0);
    chk(nrise == n, "R10", "clock pulses", nrise, n);
    chk(t_oefall - last_fall == l, "R6", "enable release", t_oefall - last_fall, l);
    chk(t_ssrise - last_fall == p, "R7", "select lag", t_ssrise - last_fall, p);
    chk(done_cnt == 1 && t_done == t_ssrise, "R8", "done count/time",
        done_cnt * 1000 + t_done - t_ssrise, 1000);
    chk(restart == 0 && ss_n && !sclk && !sdo_oe, "R11", "no second frame",
        restart, 0);
    @(negedge clk);
    chk(rx_word === (sl & mask), "R8", "received word held", rx_word, sl & mask);
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] tx, sl;
    int lens[4];
    lens = '{4, 5, 8, 13};
    rst_n = 1'b0; start = 1'b0; sdi = 1'b0; tx_word = '0; div = 8'd1; word_len = 6'd8;
    repeat (3) @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0 && sdo_oe === 1'b0 && done === 1'b0,
        "R9", "reset idle outputs", {ss_n, sclk, sdo_oe, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0 && sdo_oe === 1'b0,
        "R9", "idle after reset", {ss_n, sclk, sdo_oe}, 3'b100);
    for (int dv = 0; dv < 10; dv++) begin
      for (int li = 0; li < 4; li++) begin
        tx = 32'h9E37_79B9 * (dv + 1) + 32'(lens[li] * 7);
        sl = 32'hC2B2_AE35 ^ (tx << 3) ^ 32'(dv);
        run_xfer(dv, lens[li], tx, sl, (dv + li) % 3 == 0);
      end
    end
    run_xfer(3, 32, 32'hF00D_1234, 32'h8765_4321, 1'b1);
    run_xfer(2, 2, 32'h0000_000A, 32'h0000_0005, 1'b0);
    run_xfer(5, 40, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0);
    run_xfer(255, 6, 32'h0000_002D, 32'h0000_0013, 1'b1);
    run_xfer(254, 4, 32'h0000_0009, 32'h0000_0006, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule